// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns the system clock into a periodic clock-enable for serial channels. Software writes one 32-bit control word that holds an enable bit, a 12-bit reload value (the divisor minus one) and a select bit for a fixed divide-by-16 prescaler. The prescaler sits in front of the reload counter and reaches rates the counter alone cannot. A serial receiver that oversamples at 16 times its bit rate would be programmed for a tick rate of 16 times the bit rate.

The block has two outputs. One is a single-cycle tick, issued each time the counter reloads. The other is a square wave that changes level on every tick, so it runs at half the tick rate with 50% duty. Both are registered. Any write to the control word restarts the division from the new value, with the prescaler phase cleared, so the first tick after a write always arrives at a known cycle. Routing the outputs to channels and working out the divisor are left to the surrounding logic and to software.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset the control word reads as zero and both `tick_o` and `wave_o` are low.
- R2: Control word layout: bit 0 selects the divide-by-16 prescaler, bits 12:1 hold the divisor minus one (N), bit 16 is the enable; every other bit is not stored and reads as zero. `cfg_rdata` shows the new word from the cycle after the write edge.
- R3: While the enable bit is clear, `tick_o` and `wave_o` stay low.
- R4: With the prescaler off and N of 1 or more, `tick_o` is high for exactly one cycle every N+1 cycles, and the first tick follows N+1 clock edges after the write edge.
- R5: With N equal to zero and the prescaler off, `tick_o` is high in every cycle from the first edge after the write.
- R6: With the prescaler on, the tick period is 16*(N+1) cycles and the first tick follows 16*(N+1) edges after the write edge.
- R7: A write restarts both the counter and the prescaler from the new value. No tick is issued in the cycle after a write, and the earlier partial count has no effect on when the next tick arrives.
- R8: `wave_o` is driven low by a write and changes level on every tick. It rises with the first tick, so it is high from tick 1 up to tick 2, low from tick 2 up to tick 3, and so on.
- R9: The largest reload value, 4095, gives a period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the reference for division |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word written when `cfg_wr` is high |
| cfg_rdata | output | 32 | Stored control word, with unstored bits read as zero |
| tick_o | output | 1 | One-cycle baud tick |
| wave_o | output | 1 | Square wave at half the tick rate |

## Verification
Time is counted in clock edges from the write edge. A tick is due after edge P, 2P and so on, where P is N+1, or 16*(N+1) with the prescaler on. The square wave flips at those same edges, and the readback and the silence of both outputs are due in the very next cycle. The bench drives each write at a falling edge, then samples at every later falling edge, and compares every sampled cycle in the window with the value these formulas predict for it. This catches a tick that arrives one cycle early or late, not only a wrong tick count. Restart cases rewrite in the middle of a count and measure from the second write edge alone.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // Default geometry of the generator.
  localparam int BT_WORD_W  = 32;
  localparam int BT_CNT_W   = 12;  // reload counter width
  localparam int BT_PRE_W   = 4;   // prescaler divides by 2**BT_PRE_W
  localparam int BT_PRE_BIT = 0;   // prescaler select position
  localparam int BT_DIV_LSB = 1;   // reload field starts here
  localparam int BT_EN_BIT  = 16;  // enable position
endpackage

// File: rtl/bt_ctrl_reg.sv
module bt_ctrl_reg
  import bt_pkg::*;
#(
  parameter int CNT_W  = BT_CNT_W,
  parameter int EN_BIT = BT_EN_BIT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic [BT_WORD_W-1:0] wdata_i,
  output logic                 en_o,
  output logic                 pre_o,
  output logic [CNT_W-1:0]     reload_o,
  output logic [BT_WORD_W-1:0] word_o
);
  localparam int DIV_MSB = BT_DIV_LSB + CNT_W - 1;

  logic             en_q;
  logic             pre_q;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      pre_q    <= 1'b0;
      reload_q <= '0;
    end else if (wr_i) begin
      en_q     <= wdata_i[EN_BIT];
      pre_q    <= wdata_i[BT_PRE_BIT];
      reload_q <= wdata_i[DIV_MSB:BT_DIV_LSB];
    end
  end

  always_comb begin
    word_o                       = '0;
    word_o[BT_PRE_BIT]           = pre_q;
    word_o[DIV_MSB:BT_DIV_LSB]   = reload_q;
    word_o[EN_BIT]               = en_q;
  end

  assign en_o     = en_q;
  assign pre_o    = pre_q;
  assign reload_o = reload_q;

  // R2: a write lands in the stored word on the next edge
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (en_q == $past(wdata_i[EN_BIT])) && (reload_q == $past(wdata_i[DIV_MSB:BT_DIV_LSB])));
endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler
  import bt_pkg::*;
#(
  parameter int PRE_W = BT_PRE_W
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic en_i,
  input  logic pre_sel_i,
  output logic step_o
);
  logic [PRE_W-1:0] pre_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i || !en_i || !pre_sel_i) begin
      pre_cnt_q <= '0;
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  // One step per input cycle, or one per full prescaler wrap.
  assign step_o = en_i && (!pre_sel_i || (pre_cnt_q == {PRE_W{1'b1}}));

  // R6: the prescaler holds at zero while bypassed
  assert_pre_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !pre_sel_i |=> (pre_cnt_q == '0));
  // R7: a write clears any partial prescale count
  assert_pre_restart_R7: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (pre_cnt_q == '0));
  // R3: no step reaches the counter while disabled
  assert_step_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    step_o |-> en_i);
endmodule

// File: rtl/bt_reload_counter.sv
module bt_reload_counter
  import bt_pkg::*;
#(
  parameter int CNT_W = BT_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] restart_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             step_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= restart_val_i;
    end else if (step_i) begin
      cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
    end
  end

  assign fire_o = step_i && at_zero && !restart_i;

  // R4: the count never leaves the programmed range
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= reload_i);
  // R7: the counter starts over from the written value
  assert_cnt_restart_R7: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == $past(restart_val_i)));
endmodule

// File: rtl/bt_out_stage.sv
module bt_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic en_i,
  input  logic fire_i,
  output logic tick_o,
  output logic wave_o
);
  logic tick_q;
  logic wave_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      tick_q <= fire_i;
      if (restart_i || !en_i) begin
        wave_q <= 1'b0;
      end else if (fire_i) begin
        wave_q <= !wave_q;
      end
    end
  end

  assign tick_o = tick_q;
  assign wave_o = wave_q;

  // R8: the square wave only rises together with a tick
  assert_wave_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(wave_q) |-> tick_q);
  // R7: the cycle after a write carries no tick and a low wave
  assert_quiet_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (!tick_q && !wave_q));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import bt_pkg::*;
#(
  parameter int CNT_W  = BT_CNT_W,
  parameter int PRE_W  = BT_PRE_W,
  parameter int EN_BIT = BT_EN_BIT
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        tick_o,
  output logic        wave_o
);
  localparam int DIV_MSB = BT_DIV_LSB + CNT_W - 1;

  logic             en;
  logic             pre_sel;
  logic [CNT_W-1:0] reload;
  logic             step;
  logic             fire;

  bt_ctrl_reg #(.CNT_W(CNT_W), .EN_BIT(EN_BIT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (cfg_wr),
    .wdata_i  (cfg_wdata),
    .en_o     (en),
    .pre_o    (pre_sel),
    .reload_o (reload),
    .word_o   (cfg_rdata)
  );

  bt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .restart_i (cfg_wr),
    .en_i      (en),
    .pre_sel_i (pre_sel),
    .step_o    (step)
  );

  bt_reload_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk           (clk),
    .rst           (rst),
    .restart_i     (cfg_wr),
    .restart_val_i (cfg_wdata[DIV_MSB:BT_DIV_LSB]),
    .reload_i      (reload),
    .step_i        (step),
    .fire_o        (fire)
  );

  bt_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .restart_i (cfg_wr),
    .en_i      (en),
    .fire_i    (fire),
    .tick_o    (tick_o),
    .wave_o    (wave_o)
  );

  // R3: a disabled generator issues no tick on the following edge
  assert_silent_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick_o);
endmodule

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        tick_o;
  logic        wave_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  baud_tick_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tick_o    (tick_o),
    .wave_o    (wave_o)
  );

  function automatic logic [31:0] mk(input bit en, input bit pre, input int n);
    logic [31:0] w;
    w = 32'h0;
    w[16] = en;
    w[0] = pre;
    w[12:1] = n[11:0];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive a write at a falling edge; returns at the falling edge after the write edge.
  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = 32'h0;
  endtask

  // Sample L cycles after the write edge; P = tick period, 0 = no ticks expected.
  task automatic observe(input int L, input int P, input string tag);
    int bad_t = 0, bad_w = 0, fk_t = 0, fk_w = 0;
    bit et, ew, at_t = 0, aw = 0;
    for (int k = 1; k <= L; k++) begin
      @(posedge clk);
      @(negedge clk);
      et = (P > 0) && (k % P == 0);
      ew = (P > 0) && (((k / P) % 2) == 1);
      if (tick_o !== et) begin
        if (bad_t == 0) begin fk_t = k; at_t = tick_o; end
        bad_t++;
      end
      if (wave_o !== ew) begin
        if (bad_w == 0) begin fk_w = k; aw = wave_o; end
        bad_w++;
      end
    end
    check(bad_t == 0, tag, $sformatf("tick at cycle %0d", fk_t), at_t, !at_t);
    check(bad_w == 0, "R8", $sformatf("wave at cycle %0d (%s)", fk_w, tag), aw, !aw);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cfg_wr = 1'b0;
    cfg_wdata = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_rdata == 32'h0, "R1", "control word", cfg_rdata, 0);
    check(tick_o == 1'b0, "R1", "tick", tick_o, 0);
    check(wave_o == 1'b0, "R1", "wave", wave_o, 0);
  endtask

  task automatic t_readback;
    write_cfg(32'hFFFF_FFFF);
    check(cfg_rdata == 32'h0001_1FFF, "R2", "all-ones readback", cfg_rdata, 32'h0001_1FFF);
    write_cfg(mk(0, 1, 12'hA5C) | 32'h8000_2000);
    check(cfg_rdata == mk(0, 1, 12'hA5C), "R2", "field readback", cfg_rdata, mk(0, 1, 12'hA5C));
  endtask

  task automatic t_disabled;
    write_cfg(mk(1, 0, 2));
    observe(7, 3, "R4");
    write_cfg(mk(0, 0, 2) | 32'hFFFE_0000);
    check(tick_o == 1'b0 && wave_o == 1'b0, "R3", "outputs right after disable",
          {tick_o, wave_o}, 0);
    observe(40, 0, "R3");
  endtask

  task automatic t_plain;
    write_cfg(mk(1, 0, 5));
    observe(40, 6, "R4");
    write_cfg(mk(1, 0, 1));
    observe(12, 2, "R4");
  endtask

  task automatic t_div1;
    write_cfg(mk(1, 0, 0));
    observe(10, 1, "R5");
  endtask

  task automatic t_prescale;
    write_cfg(mk(1, 1, 2));
    observe(150, 48, "R6");
    write_cfg(mk(1, 1, 0));
    observe(50, 16, "R6");
  endtask

  task automatic t_restart;
    write_cfg(mk(1, 0, 9));
    observe(15, 10, "R7");
    write_cfg(mk(1, 0, 4));
    check(tick_o == 1'b0, "R7", "tick after rewrite", tick_o, 0);
    check(wave_o == 1'b0, "R7", "wave after rewrite", wave_o, 0);
    observe(20, 5, "R7");
    write_cfg(mk(1, 1, 1));
    observe(21, 32, "R7");
    write_cfg(mk(1, 1, 1));
    observe(70, 32, "R7");
  endtask

  task automatic t_max;
    write_cfg(mk(1, 0, 4095));
    observe(8200, 4096, "R9");
  endtask

  initial begin
    t_reset();
    t_readback();
    t_disabled();
    t_plain();
    t_div1();
    t_prescale();
    t_restart();
    t_max();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule